// File: doc/BRIEF.md
# Dual-Rail Null-Convention Register Stage

This block is one register stage of a dual-rail, null-convention pipeline. Each bit of the data word travels on two rails: a true rail and a false rail. The stage stores every rail in a two-input hysteresis cell. Each cell pairs its incoming rail with the acknowledge level that comes back from the next stage. A cell rises only when the rail and that acknowledge are both high. It falls only when both are low. In every other case it keeps its value.

A completion tree watches the stored word and reports two conditions: every bit holds a valid code, or every bit is empty. A two-state handshake machine uses that report to drive the acknowledge sent back to the previous stage, so the pipeline moves through the four-phase sequence:

1. A NULL wavefront is accepted.
2. DATA is requested.
3. A DATA wavefront is accepted.
4. NULL is requested.

The stage is modelled cycle by cycle on a sampling clock. Each hysteresis cell and the handshake state are flops that re-evaluate at every edge. The machine has two states:

- `ST_REQ_DATA`: the acknowledge is high and DATA is requested.
- `ST_REQ_NULL`: the acknowledge is low and NULL is requested.

It has two transitions:

- `T_DATA_FULL` moves from `ST_REQ_DATA` to `ST_REQ_NULL` once the stored word is entirely DATA.
- `T_NULL_FULL` moves from `ST_REQ_NULL` to `ST_REQ_DATA` once the stored word is entirely NULL.

If neither condition holds, the machine stays where it is.

Top module: `ncl_reg_stage`

## Requirements
- R1: While reset is asserted (`rst_n` low), every stored rail is 0, so both output rail vectors read all zeros. The acknowledge to the previous stage is 1, which requests DATA.
- R2: Bit i is encoded on two rails. True rail high and false rail low means logic 1. False rail high and true rail low means logic 0. Both rails low means NULL, and both rails high is illegal. A stored rail goes to 1 at the first clock edge at which its input rail and `ack_in` are both 1.
- R3: A stored rail goes to 0 at the first clock edge at which its input rail and `ack_in` are both 0.
- R4: If a rail's input and `ack_in` differ at an edge, that stored rail keeps its previous value.
- R5: In `ST_REQ_DATA`, once every bit of the stored word has at least one rail high, `ack_out` drops to 0 at the next edge (transition `T_DATA_FULL`).
- R6: In `ST_REQ_NULL`, once every stored rail is 0, `ack_out` rises to 1 at the next edge (transition `T_NULL_FULL`).
- R7: While the stored word is partly DATA and partly NULL, `ack_out` does not change.
- R8: When the stage is run between a four-phase source and sink, every DATA word reaches the output rails unchanged and in order. No word is lost and no word is delivered twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the cell and handshake flops |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_t | input | WIDTH | True rails of the incoming word |
| in_f | input | WIDTH | False rails of the incoming word |
| ack_in | input | 1 | Acknowledge from the next stage (1 requests DATA, 0 requests NULL) |
| out_t | output | WIDTH | Stored true rails |
| out_f | output | WIDTH | Stored false rails |
| ack_out | output | 1 | Acknowledge to the previous stage (1 requests DATA, 0 requests NULL) |

## Verification
A rail that the bench changes before edge k shows on `out_t` and `out_f` just after edge k. `ack_out` reacts to that stored word one edge later, at k+1. The directed checks therefore sample at the falling edge after k to see the rails, and at the falling edge after k+1 to see `ack_out`. At the edge k sample they also confirm that `ack_out` has not yet moved. The flow runs send all sixteen 4-bit values three times, each time with a different source and sink response delay. The source and sink models poll only at falling edges. Each received word is compared with the value expected next in the sequence.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

    typedef enum logic {
        ST_REQ_DATA = 1'b0,
        ST_REQ_NULL = 1'b1
    } hs_state_e;

    // two-input hysteresis: rise on 11, fall on 00, hold otherwise
    function automatic logic hyst2(input logic a, input logic b, input logic q);
        if (a && b)
            return 1'b1;
        else if (!a && !b)
            return 1'b0;
        else
            return q;
    endfunction

endpackage

// File: rtl/ncl_c2_bank.sv
module ncl_c2_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_in,
    input  logic             gate_in,
    output logic [WIDTH-1:0] rail_q
);
    import ncl_pkg::*;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rail_q[g] <= 1'b0;
            else
                rail_q[g] <= hyst2(rail_in[g], gate_in, rail_q[g]);
        end
    end

endmodule

// File: rtl/ncl_done_tree.sv
module ncl_done_tree #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] st_t,
    input  logic [WIDTH-1:0] st_f,
    output logic             word_data,
    output logic             word_null
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] nd_data;
    logic [NODES-1:0] nd_null;

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < WIDTH) begin : g_real
            assign nd_data[LEAVES-1+l] = st_t[l] | st_f[l];
            assign nd_null[LEAVES-1+l] = ~(st_t[l] | st_f[l]);
        end else begin : g_pad
            assign nd_data[LEAVES-1+l] = 1'b1;
            assign nd_null[LEAVES-1+l] = 1'b1;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        assign nd_data[n] = nd_data[2*n+1] & nd_data[2*n+2];
        assign nd_null[n] = nd_null[2*n+1] & nd_null[2*n+2];
    end

    assign word_data = nd_data[0];
    assign word_null = nd_null[0];

endmodule

// File: rtl/ncl_hs_fsm.sv
module ncl_hs_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic word_data,
    input  logic word_null,
    output logic req_data
);
    import ncl_pkg::*;

    hs_state_e state_q;
    hs_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_REQ_DATA;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REQ_DATA: if (word_data) state_d = ST_REQ_NULL;  // T_DATA_FULL
            ST_REQ_NULL: if (word_null) state_d = ST_REQ_DATA;  // T_NULL_FULL
            default:     state_d = ST_REQ_DATA;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_REQ_DATA: req_data = 1'b1;
            ST_REQ_NULL: req_data = 1'b0;
            default:     req_data = 1'b1;
        endcase
    end

endmodule

// File: rtl/ncl_reg_stage.sv
module ncl_reg_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    input  logic             ack_in,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f,
    output logic             ack_out
);
    logic word_data;
    logic word_null;

    ncl_c2_bank #(.WIDTH(WIDTH)) u_bank_t (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail_in (in_t),
        .gate_in (ack_in),
        .rail_q  (out_t)
    );

    ncl_c2_bank #(.WIDTH(WIDTH)) u_bank_f (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail_in (in_f),
        .gate_in (ack_in),
        .rail_q  (out_f)
    );

    ncl_done_tree #(.WIDTH(WIDTH)) u_done (
        .st_t      (out_t),
        .st_f      (out_f),
        .word_data (word_data),
        .word_null (word_null)
    );

    ncl_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_data (word_data),
        .word_null (word_null),
        .req_data  (ack_out)
    );

endmodule

// File: rtl/ncl_reg_stage_chk.sv
module ncl_reg_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] in_t,
    input logic [WIDTH-1:0] in_f,
    input logic             ack_in,
    input logic [WIDTH-1:0] out_t,
    input logic [WIDTH-1:0] out_f,
    input logic             ack_out
);
    logic all_dat;
    logic all_nul;
    assign all_dat = &(out_t | out_f);
    assign all_nul = ((out_t | out_f) == '0);

    a_r2_set_rails: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in |=> (((out_t & $past(in_t)) == $past(in_t)) && ((out_f & $past(in_f)) == $past(in_f))));

    a_r3_clear_rails: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_in |=> (((out_t & ~$past(in_t)) == '0) && ((out_f & ~$past(in_f)) == '0)));

    a_r4_hold_low_in: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in |=> (((out_t & ~$past(in_t)) == ($past(out_t) & ~$past(in_t)))
                 && ((out_f & ~$past(in_f)) == ($past(out_f) & ~$past(in_f)))));

    a_r4_hold_high_in: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_in |=> (((out_t & $past(in_t)) == ($past(out_t) & $past(in_t)))
                  && ((out_f & $past(in_f)) == ($past(out_f) & $past(in_f)))));

    a_r5_ack_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && all_dat) |=> !ack_out);

    a_r6_ack_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_out && all_nul) |=> ack_out);

    a_r7_partial_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_dat && !all_nul) |=> $stable(ack_out));

endmodule

bind ncl_reg_stage ncl_reg_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_t    (in_t),
    .in_f    (in_f),
    .ack_in  (ack_in),
    .out_t   (out_t),
    .out_f   (out_f),
    .ack_out (ack_out)
);

// File: tb/tb_ncl_reg_stage.sv
`timescale 1ns/1ps
module tb_ncl_reg_stage;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_t = '0;
    logic [W-1:0] in_f = '0;
    logic         ack_in = 1'b1;
    logic [W-1:0] out_t;
    logic [W-1:0] out_f;
    logic         ack_out;

    int n_chk = 0;
    int n_bad = 0;
    int rx_idx;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ncl_reg_stage #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
        .ack_in(ack_in), .out_t(out_t), .out_f(out_f), .ack_out(ack_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_t = '0; in_f = '0; ack_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 out_t", 32'(out_t), 0);
        chk("R1 out_f", 32'(out_f), 0);
        chk("R1 ack_out", 32'(ack_out), 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic source(input int dly, input int pass);
        for (int v = 0; v < (1 << W); v++) begin
            while (!ack_out) @(negedge clk);
            repeat (dly) @(negedge clk);
            in_t = W'((v + pass) % (1 << W));
            in_f = ~in_t;
            while (ack_out) @(negedge clk);
            repeat (dly) @(negedge clk);
            in_t = '0; in_f = '0;
        end
    endtask

    task automatic sink(input int dly, input int pass);
        for (int v = 0; v < (1 << W); v++) begin
            while (!(&(out_t | out_f))) @(negedge clk);
            // R8: one delivery per DATA phase, in sequence
            chk("R8 word", 32'(out_t), 32'((v + pass) % (1 << W)));
            chk("R8 rails", 32'(out_f), 32'(W'(~out_t)));
            rx_idx++;
            repeat (dly) @(negedge clk);
            ack_in = 1'b0;
            while ((out_t | out_f) != '0) @(negedge clk);
            repeat (dly) @(negedge clk);
            ack_in = 1'b1;
        end
    endtask

    initial begin
        do_reset();

        // R2, R7: fill the word one bit at a time, ack_in high
        ack_in = 1'b1;
        in_t = 4'b0001; in_f = 4'b0000;
        @(negedge clk);
        chk("R2 set one rail", 32'(out_t), 32'h1);
        @(negedge clk);
        chk("R7 partial ack", 32'(ack_out), 1);
        in_f = 4'b0010;
        @(negedge clk);
        chk("R2 false rail", 32'(out_f), 32'h2);
        chk("R7 partial ack2", 32'(ack_out), 1);
        in_t = 4'b1001; in_f = 4'b0110;
        @(negedge clk);
        chk("R2 full word t", 32'(out_t), 32'h9);
        chk("R5 ack not yet", 32'(ack_out), 1);
        @(negedge clk);
        chk("R5 ack fell", 32'(ack_out), 0);

        // R4: inputs go NULL while ack_in still high -> hold
        in_t = '0; in_f = '0;
        repeat (2) @(negedge clk);
        chk("R4 hold t", 32'(out_t), 32'h9);
        chk("R4 hold f", 32'(out_f), 32'h6);
        chk("R4 ack held", 32'(ack_out), 0);

        // R3/R4: ack_in low with a different DATA word -> out = stored & in
        ack_in = 1'b0;
        in_t = 4'b0011; in_f = 4'b1100;
        @(negedge clk);
        chk("R3 R4 t", 32'(out_t), 32'h1);
        chk("R3 R4 f", 32'(out_f), 32'h4);
        chk("R7 partial low", 32'(ack_out), 0);
        in_t = '0; in_f = '0;
        @(negedge clk);
        chk("R3 clear t", 32'(out_t), 0);
        chk("R3 clear f", 32'(out_f), 0);
        chk("R6 ack not yet", 32'(ack_out), 0);
        @(negedge clk);
        chk("R6 ack rose", 32'(ack_out), 1);

        // R8: four-phase flow, three delay settings
        for (int p = 0; p < 3; p++) begin
            do_reset();
            rx_idx = 0;
            fork
                source(p, p * 5);
                sink(2 - p, p * 5);
            join
            chk("R8 count", 32'(rx_idx), 32'(1 << W));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule